// File: doc/BRIEF.md
# DRAM Self-Refresh Backup Sequencer

This block sits beside a DDR2 memory controller and takes the memory into a self-refresh state that survives the loss of main power. It also decides how the memory is brought back once power returns. When a backup request is made and the access path has nothing outstanding, the block stops new accesses. It then stops automatic refresh, closes all banks, and issues one refresh. Last, it issues the self-refresh entry command and drops clock enable. Each command is spaced by a parameterised minimum gap. The whole run has to finish before the controller's next refresh falls due. If the refresh-deadline tick arrives first, the block gives up, returns to normal operation and raises an error flag.

Once self-refresh is entered, a status bit and a notify output go high, so that an external supervisor can pull the backup-reset line low before power is cut. After a power-on reset, the block holds clock enable low and does nothing until the backup-reset line rises. At that rise, a select input picks one of two paths. The first leaves self-refresh, issues one refresh, and then re-enables automatic refresh and accesses, in that order. The second hands the memory to the normal initialization sequence with a one-cycle start pulse.

Top module: `sr_backup_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cke`, `acc_en`, `aref_en`, `cmd_vld`, `sr_status` and `notify` are all 0.
- R2: After reset the block takes no action, with every enable and `cke` held at 0, until `bkp_rst_n` has been seen low and then high. A level held high or low starts nothing.
- R3: On the release edge with `resume_sel` = 0, `init_go` pulses for exactly one cycle. In that same cycle `acc_en`, `aref_en` and `cke` are 1.
- R4: A backup request is accepted only in a cycle where `path_idle` = 1. While `path_idle` = 0, `acc_en` stays 1 and no command is issued.
- R5: After acceptance, `acc_en` falls in the next cycle and `aref_en` falls one cycle later. The precharge-all strobe comes one cycle after that. `acc_en` is never 1 while `aref_en` is 0, and no command is issued while `acc_en` is 1.
- R6: Command codes on `cmd_code` are: 0 no-op, 1 precharge-all, 2 refresh, 3 self-refresh entry, 4 self-refresh exit. On entry, refresh comes T_RP cycles after precharge-all, and self-refresh entry comes T_RFC cycles after refresh. No other commands are issued.
- R7: `cmd_vld` is a single-cycle strobe and is never high in two consecutive cycles.
- R8: In the self-refresh entry cycle `cke` is 0. From the next cycle `sr_status` and `notify` are 1, and `cke` stays 0 until reset.
- R9: A `ref_due` pulse seen before the self-refresh entry command ends the sequence. From the next cycle no further entry command is issued, `abort_err` = 1, and `acc_en` = `aref_en` = 1. `abort_err` clears when the next request is accepted.
- R10: On the release edge with `resume_sel` = 1, self-refresh exit is issued with `cke` = 1. Refresh follows T_XSR cycles later. `aref_en` rises T_RFC cycles after that refresh, and `acc_en` rises one cycle after `aref_en`.
- R11: `ref_due` has no effect in normal operation or in the backup state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bkp_req | input | 1 | Request to enter the backup state |
| path_idle | input | 1 | Access path has no outstanding transaction |
| ref_due | input | 1 | Refresh-deadline tick |
| bkp_rst_n | input | 1 | Backup-reset line from the external supervisor |
| resume_sel | input | 1 | 1: resume from backup, 0: full initialization |
| acc_en | output | 1 | Access enable to the controller |
| aref_en | output | 1 | Automatic refresh enable |
| cmd_vld | output | 1 | Command strobe |
| cmd_code | output | 3 | Encoded command |
| cke | output | 1 | Memory clock enable |
| sr_status | output | 1 | Readable self-refresh-entered status |
| notify | output | 1 | Notification to the external supervisor |
| abort_err | output | 1 | Entry aborted by refresh deadline |
| init_go | output | 1 | Start pulse for the normal initialization sequence |

## Verification
The bench builds the block with T_RP = 3, T_RFC = 5, T_XSR = 4 and a two-stage synchronizer on the backup-reset line. With gaps this short, every command spacing and every enable edge can be counted cycle by cycle. A deadline tick can also be placed inside the precharge wait to force an abort. The two synchronizer stages put a real delay between the release edge and the first action, which the bench tolerates rather than pins.

// File: rtl/srb_pkg.sv
package srb_pkg;

   // Command encoding (R6)
   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_PALL = 3'd1,
      CMD_REF  = 3'd2,
      CMD_SRE  = 3'd3,
      CMD_SRX  = 3'd4
   } srb_cmd_e;

   typedef enum logic [3:0] {
      ST_WREL, ST_NORM, ST_BLK, ST_NOAR, ST_PALL, ST_WPA, ST_REF, ST_WRF,
      ST_SRE, ST_BKP, ST_SRX, ST_WSX, ST_RREF, ST_WRR, ST_RAR
   } srb_state_e;

endpackage

// File: rtl/srb_edge_sync.sv
module srb_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic lvl;
   logic prev;

   generate
      if (STAGES == 0) begin : g_direct
         assign lvl = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[STAGES-2+((STAGES==1)?1:0):0], din} ;
         end
         assign lvl = sh[STAGES-1];
      end
   endgenerate

   // Previous level resets high: a line already high at reset is no rise (R2)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
endmodule

// File: rtl/srb_gap_timer.sv
module srb_gap_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/sr_backup_seq.sv
module sr_backup_seq #(
   parameter int T_RP        = 6,
   parameter int T_RFC       = 52,
   parameter int T_XSR       = 200,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bkp_req,
   input  logic       path_idle,
   input  logic       ref_due,
   input  logic       bkp_rst_n,
   input  logic       resume_sel,
   output logic       acc_en,
   output logic       aref_en,
   output logic       cmd_vld,
   output logic [2:0] cmd_code,
   output logic       cke,
   output logic       sr_status,
   output logic       notify,
   output logic       abort_err,
   output logic       init_go
);
   import srb_pkg::*;

   localparam int TMAX = (T_RP > T_RFC) ? ((T_RP > T_XSR) ? T_RP : T_XSR)
                                        : ((T_RFC > T_XSR) ? T_RFC : T_XSR);
   localparam int CW = (TMAX < 4) ? 2 : $clog2(TMAX);
   localparam logic [CW-1:0] V_RP  = CW'(T_RP - 2);
   localparam logic [CW-1:0] V_RFC = CW'(T_RFC - 2);
   localparam logic [CW-1:0] V_XSR = CW'(T_XSR - 2);

   generate
      if (T_RP < 2 || T_RFC < 2 || T_XSR < 2) begin : g_bad_gap
         $error("sr_backup_seq: every command gap must be at least 2 cycles");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("sr_backup_seq: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   srb_state_e st, nxt;
   srb_cmd_e   cmd;
   logic       rel_rise, t_zero, t_load, accept, abort;
   logic [CW-1:0] t_val;

   srb_edge_sync #(.STAGES(SYNC_STAGES)) u_rel (
      .clk(clk), .rst_n(rst_n), .din(bkp_rst_n), .rise(rel_rise)
   );

   srb_gap_timer #(.W(CW)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .zero(t_zero)
   );

   always_comb begin
      nxt    = st;
      t_load = 1'b0;
      t_val  = '0;
      accept = 1'b0;
      abort  = 1'b0;
      unique case (st)
         ST_WREL: if (rel_rise) nxt = resume_sel ? ST_SRX : ST_NORM;  // R2, R3
         ST_NORM: if (bkp_req && path_idle) begin                      // R4
            nxt    = ST_BLK;
            accept = 1'b1;
         end
         ST_BLK:  nxt = ST_NOAR;
         ST_NOAR: nxt = ST_PALL;
         ST_PALL: begin t_load = 1'b1; t_val = V_RP;  nxt = ST_WPA; end
         ST_WPA:  if (t_zero) nxt = ST_REF;
         ST_REF:  begin t_load = 1'b1; t_val = V_RFC; nxt = ST_WRF; end
         ST_WRF:  if (t_zero) nxt = ST_SRE;
         ST_SRE:  nxt = ST_BKP;
         ST_BKP:  nxt = ST_BKP;
         ST_SRX:  begin t_load = 1'b1; t_val = V_XSR; nxt = ST_WSX; end
         ST_WSX:  if (t_zero) nxt = ST_RREF;
         ST_RREF: begin t_load = 1'b1; t_val = V_RFC; nxt = ST_WRR; end
         ST_WRR:  if (t_zero) nxt = ST_RAR;
         ST_RAR:  nxt = ST_NORM;
         default: nxt = ST_WREL;
      endcase
      // Deadline abort before self-refresh entry (R9)
      if (ref_due && (st inside {ST_BLK, ST_NOAR, ST_PALL, ST_WPA, ST_REF, ST_WRF})) begin
         nxt   = ST_NORM;
         abort = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_WREL;
         abort_err <= 1'b0;
         init_go   <= 1'b0;
      end else begin
         st      <= nxt;
         init_go <= (st == ST_WREL) && rel_rise && !resume_sel;
         if (abort)       abort_err <= 1'b1;
         else if (accept) abort_err <= 1'b0;
      end
   end

   always_comb begin
      unique case (st)
         ST_PALL:         cmd = CMD_PALL;
         ST_REF, ST_RREF: cmd = CMD_REF;
         ST_SRE:          cmd = CMD_SRE;
         ST_SRX:          cmd = CMD_SRX;
         default:         cmd = CMD_NOP;
      endcase
   end

   assign cmd_code  = cmd;
   assign cmd_vld   = (cmd != CMD_NOP);
   assign acc_en    = (st == ST_NORM);
   assign aref_en   = (st inside {ST_NORM, ST_BLK, ST_RAR});
   assign cke       = !(st inside {ST_WREL, ST_SRE, ST_BKP});   // R8
   assign sr_status = (st == ST_BKP);
   assign notify    = (st == ST_BKP);
endmodule

// File: rtl/srb_check.sv
module srb_check (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_en,
   input logic       aref_en,
   input logic       cmd_vld,
   input logic [2:0] cmd_code,
   input logic       cke,
   input logic       sr_status,
   input logic       notify,
   input logic       abort_err,
   input logic       init_go
);
   p_cke_low_reset_r1: assert property (@(posedge clk) !rst_n |-> !cke);

   p_init_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      init_go |=> !init_go);

   p_no_cmd_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |-> !acc_en);

   p_enable_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en |-> aref_en);

   p_code_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |-> (cmd_code != 3'd0 && cmd_code <= 3'd4));

   p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |=> !cmd_vld);

   p_status_after_sre_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_status) |-> $past(cmd_vld && cmd_code == 3'd3));

   p_status_cke_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sr_status |-> (!cke && notify));

   p_abort_resumes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_err) |-> (acc_en && aref_en && !sr_status));
endmodule

bind sr_backup_seq srb_check u_srb_check (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .aref_en(aref_en),
   .cmd_vld(cmd_vld), .cmd_code(cmd_code), .cke(cke), .sr_status(sr_status),
   .notify(notify), .abort_err(abort_err), .init_go(init_go)
);

// File: tb/sr_backup_seq_test.sv
module sr_backup_seq_test;
   localparam int TRP = 3, TRFC = 5, TXSR = 4, SYN = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, bkp_req, path_idle, ref_due, bkp_rst_n, resume_sel;
   logic acc_en, aref_en, cmd_vld, cke, sr_status, notify, abort_err, init_go;
   logic [2:0] cmd_code;

   sr_backup_seq #(.T_RP(TRP), .T_RFC(TRFC), .T_XSR(TXSR), .SYNC_STAGES(SYN)) uut (
      .clk(clk), .rst_n(rst_n), .bkp_req(bkp_req), .path_idle(path_idle),
      .ref_due(ref_due), .bkp_rst_n(bkp_rst_n), .resume_sel(resume_sel),
      .acc_en(acc_en), .aref_en(aref_en), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
      .cke(cke), .sr_status(sr_status), .notify(notify), .abort_err(abort_err),
      .init_go(init_go)
   );

   int n_chk = 0, n_err = 0;
   int cyc = 0;
   bit done = 0;
   always @(posedge clk) cyc++;

   typedef struct { logic [2:0] code; int gap; } exp_t;
   exp_t q[$];
   exp_t e;
   int   last = 0;
   logic prev_vld = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input logic [2:0] c, input int g);
      exp_t x;
      x.code = c; x.gap = g;
      q.push_back(x);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // Monitor: pops expected commands as the design strobes them (R6, R7)
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (cmd_vld) begin
            if (prev_vld) chk(1'b0, "R7 strobe held two cycles", 1, 0);
            if (q.size() == 0) chk(1'b0, "R6 unexpected command", int'(cmd_code), 0);
            else begin
               e = q.pop_front();
               chk(cmd_code == e.code, "R6 command code", int'(cmd_code), int'(e.code));
               if (e.gap > 0) chk(cyc - last == e.gap, "R6 command spacing", cyc - last, e.gap);
            end
            last = cyc;
         end
         prev_vld = cmd_vld;
      end else prev_vld = 1'b0;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      bit ok;
      int ka, kr;
      rst_n = 0; bkp_req = 0; path_idle = 0; ref_due = 0; bkp_rst_n = 1; resume_sel = 0;
      repeat (3) @(negedge clk);
      chk(!cke && !acc_en && !aref_en && !cmd_vld && !sr_status && !notify,
          "R1 outputs during reset", int'(cke), 0);
      rst_n = 1;
      @(negedge clk);
      chk(!cke && !acc_en && !aref_en && !sr_status, "R1 first cycle after reset", int'(acc_en), 0);

      // R2: high level alone starts nothing, low level alone starts nothing
      ok = 1;
      repeat (20) begin @(negedge clk); if (acc_en || cke || init_go) ok = 0; end
      chk(ok, "R2 idle while line held high", int'(ok), 1);
      bkp_rst_n = 0;
      repeat (6) begin @(negedge clk); if (acc_en || cke || init_go) ok = 0; end
      chk(ok, "R2 idle while line held low", int'(ok), 1);

      // R3: initialization hand-off
      resume_sel = 0; bkp_rst_n = 1;
      ok = 0;
      for (int i = 0; i < 10 && !ok; i++) begin @(negedge clk); if (init_go) ok = 1; end
      chk(ok, "R3 init_go seen after release", int'(ok), 1);
      chk(acc_en && aref_en && cke, "R3 enables with init_go", int'(acc_en), 1);
      @(negedge clk);
      chk(!init_go, "R3 init_go single pulse", int'(init_go), 0);

      // R4: request held while path busy
      bkp_req = 1; path_idle = 0;
      ok = 1;
      repeat (10) begin @(negedge clk); if (!acc_en) ok = 0; end
      chk(ok, "R4 no acceptance while busy", int'(ok), 1);

      // R5/R6/R8: full entry
      push(3'd1, 0); push(3'd2, TRP); push(3'd3, TRFC);
      path_idle = 1;
      @(negedge clk);
      bkp_req = 0;
      chk(!acc_en && aref_en, "R5 access disabled first", int'(acc_en), 0);
      @(negedge clk);
      chk(!acc_en && !aref_en && !cmd_vld, "R5 refresh disabled second", int'(aref_en), 0);
      @(negedge clk);
      chk(cmd_vld && cmd_code == 3'd1, "R5 precharge-all third", int'(cmd_code), 1);
      ok = 0;
      for (int i = 0; i < 30 && !ok; i++) begin
         @(negedge clk);
         if (cmd_vld && cmd_code == 3'd3) ok = 1;
      end
      chk(ok, "R8 self-refresh entry issued", int'(ok), 1);
      chk(!cke, "R8 cke low at entry", int'(cke), 0);
      @(negedge clk);
      chk(sr_status && notify && !cke, "R8 status and notify", int'(sr_status), 1);
      ref_due = 1;
      @(negedge clk);
      ref_due = 0;
      ok = 1;
      repeat (8) begin @(negedge clk); if (!sr_status || !notify || cke || acc_en) ok = 0; end
      chk(ok, "R11 tick ignored in backup state", int'(ok), 1);
      chk(q.size() == 0, "R6 entry commands complete", q.size(), 0);

      // Power loss and recovery (R1, R2, R10)
      rst_n = 0; bkp_rst_n = 0;
      repeat (3) @(negedge clk);
      chk(!cke, "R1 cke low through reset", int'(cke), 0);
      rst_n = 1;
      ok = 1;
      repeat (5) begin @(negedge clk); if (cke || acc_en || sr_status) ok = 0; end
      chk(ok, "R2 waits with line low", int'(ok), 1);
      push(3'd4, 0); push(3'd2, TXSR);
      resume_sel = 1; bkp_rst_n = 1;
      ok = 0;
      for (int i = 0; i < 10 && !ok; i++) begin @(negedge clk); if (cmd_vld) ok = 1; end
      chk(ok && cmd_code == 3'd4, "R10 exit command issued", int'(cmd_code), 4);
      chk(cke, "R10 cke high at exit", int'(cke), 1);
      ok = 0;
      for (int i = 0; i < 10 && !ok; i++) begin
         @(negedge clk);
         if (cmd_vld && cmd_code == 3'd2) ok = 1;
      end
      chk(ok, "R10 recovery refresh issued", int'(ok), 1);
      ka = 0; kr = 0;
      for (int k = 1; k <= TRFC + 2; k++) begin
         @(negedge clk);
         if (aref_en && kr == 0) kr = k;
         if (acc_en && ka == 0) ka = k;
      end
      chk(kr == TRFC, "R10 refresh re-enable delay", kr, TRFC);
      chk(ka == TRFC + 1, "R10 access re-enable delay", ka, TRFC + 1);
      chk(q.size() == 0, "R6 recovery commands complete", q.size(), 0);

      // R11: tick in normal operation
      ref_due = 1;
      @(negedge clk);
      ref_due = 0;
      @(negedge clk);
      chk(acc_en && aref_en && !abort_err && !cmd_vld, "R11 tick ignored in normal", int'(abort_err), 0);

      // R9: abort during precharge wait
      push(3'd1, 0);
      bkp_req = 1; path_idle = 1;
      @(negedge clk);
      bkp_req = 0;
      ok = 0;
      for (int i = 0; i < 5 && !ok; i++) begin @(negedge clk); if (cmd_vld) ok = 1; end
      ref_due = 1;
      @(negedge clk);
      ref_due = 0;
      chk(abort_err, "R9 error flag raised", int'(abort_err), 1);
      chk(acc_en && aref_en && !sr_status, "R9 back to normal", int'(acc_en), 1);
      repeat (TRP + TRFC + 4) @(negedge clk);
      chk(q.size() == 0 && abort_err && !sr_status, "R9 no further entry commands",
          q.size(), 0);

      // R9: retry clears the flag and completes
      push(3'd1, 0); push(3'd2, TRP); push(3'd3, TRFC);
      bkp_req = 1;
      @(negedge clk);
      bkp_req = 0;
      chk(!abort_err, "R9 flag cleared on acceptance", int'(abort_err), 0);
      ok = 0;
      for (int i = 0; i < 30 && !ok; i++) begin @(negedge clk); if (sr_status) ok = 1; end
      chk(ok && q.size() == 0, "R8 retry reaches backup", q.size(), 0);

      done = 1;
      summary();
      $finish;
   end
endmodule